// File: doc/BRIEF.md
# Interrupt Priority Level Decoder

This block turns three active-low interrupt-request pins into a pending priority level, decides whether that level may interrupt the processor, and produces the vector number used once the processor acknowledges the request. The pins are brought into the clock domain through a synchroniser. A level is accepted only after it reads the same on two consecutive synchronised samples, so a short glitch never raises a request.

Levels 1 to 6 are maskable. Each is compared with the 3-bit priority mask from the status register, and it requests service only when it is strictly higher than the mask. Level 7 is non-maskable and is edge sensitive. When the accepted level first becomes 7, a pending flag is set. That flag holds until software clears it, whatever the mask says.

When an acknowledge completes, the result strobe updates the vector output. If a device responded, the vector is the autovector for the level being serviced. If no device responded, the vector is the spurious-interrupt vector.

Top module: `irq_level_decoder`

## Requirements
- R1: The request level is the bitwise inverse of the pins. All pins high means level 0, and level 0 never raises a request.
- R2: A level from 1 to 6 raises `irq_req` with `irq_level` equal to that level only when it is strictly greater than `ipl_mask`. Otherwise `irq_req` is 0 and `irq_level` is 0.
- R3: A level-7 request raises `irq_req` with `irq_level` = 7 for every mask value, including mask 7.
- R4: Once raised, a level-7 request stays asserted until `nmi_clear` is pulsed. If the pins keep showing 7 after the clear, there is no new request. A new request needs the level to leave 7 and then return to it.
- R5: A pin pattern that lasts only one clock cycle is ignored. It raises no request.
- R6: For levels 1 to 6, `irq_req` rises on the 5th rising clock edge after the pins change: two synchroniser stages, two stability samples, and one output register. It has not risen after the 4th edge. A change of `ipl_mask` takes effect on the next edge.
- R7: On an `ack_done` strobe with `ack_none` = 0, `vec_num` becomes 24 + `irq_level` on the next edge. This gives vectors 25 to 31 for levels 1 to 7.
- R8: On an `ack_done` strobe with `ack_none` = 1, `vec_num` becomes 24, the spurious vector.
- R9: Synchronous active-high reset sets `irq_req` to 0, `irq_level` to 0 and `vec_num` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_n | input | 3 | Interrupt-request pins, active low, asynchronous |
| ipl_mask | input | 3 | Priority mask from the status register |
| nmi_clear | input | 1 | Clears a latched level-7 request |
| ack_done | input | 1 | One-cycle strobe: acknowledge result available |
| ack_none | input | 1 | With `ack_done`: no device responded |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_level | output | 3 | Level to be serviced, 0 when no request |
| vec_num | output | 8 | Vector number from the last acknowledge |

## Verification
The main function is exercised with several levels against several mask values.

- A level below the mask, a level equal to the mask, and a level above it separate the strict comparison from an off-by-one comparison.
- Level 7 under mask 7 tells the non-maskable path apart from the maskable one.
- Holding level 7 across a clear, and then removing and restoring it, separates edge detection from level detection.
- A one-cycle pin pulse, and a count of the edges up to the request, pin down the synchroniser and the stability filter.
- Acknowledges with and without a responder, at several levels, cover the autovector and spurious vector mapping.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int LVL_W        = 3;
    localparam int VEC_W        = 8;
    localparam int VEC_SPURIOUS = 24;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;

    localparam lvl_t LVL_NONE = '0;
    localparam lvl_t LVL_NMI  = '1;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } irq_out_t;

    // Active-low pins: the inverted pattern is the level
    function automatic lvl_t pins_to_lvl(input lvl_t pins_n);
        return ~pins_n;
    endfunction

    function automatic vec_t auto_vec(input lvl_t l);
        return vec_t'(VEC_SPURIOUS) + vec_t'(l);
    endfunction

endpackage

// File: rtl/irqd_sync.sv
module irqd_sync
    import irqd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  lvl_t pins_n,
    output lvl_t lvl_stable
);
    lvl_t chain [SYNC_STAGES];
    lvl_t prev_q;
    lvl_t acc_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= LVL_NONE;
                    else     chain[0] <= pins_to_lvl(pins_n);
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= LVL_NONE;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Accept a level only when two consecutive samples agree
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= LVL_NONE;
            acc_q  <= LVL_NONE;
        end else begin
            prev_q <= chain[SYNC_STAGES-1];
            if (chain[SYNC_STAGES-1] == prev_q)
                acc_q <= prev_q;
        end
    end

    assign lvl_stable = acc_q;
endmodule

// File: rtl/irqd_nmi.sv
module irqd_nmi
    import irqd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t lvl,
    input  logic clear,
    output logic pend
);
    logic at7_q;
    logic pend_q;
    logic rise;

    assign rise = (lvl == LVL_NMI) && !at7_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            at7_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            at7_q <= (lvl == LVL_NMI);
            // a fresh edge wins over a clear in the same cycle
            if (rise)       pend_q <= 1'b1;
            else if (clear) pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/irqd_select.sv
module irqd_select
    import irqd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_t     lvl,
    input  lvl_t     mask,
    input  logic     nmi_pend,
    output irq_out_t out
);
    irq_out_t nxt;
    irq_out_t out_q;

    always_comb begin
        nxt = '{req: 1'b0, lvl: LVL_NONE};
        if (nmi_pend)
            nxt = '{req: 1'b1, lvl: LVL_NMI};
        else if (lvl != LVL_NMI && lvl > mask)
            nxt = '{req: 1'b1, lvl: lvl};
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '{req: 1'b0, lvl: LVL_NONE};
        else     out_q <= nxt;
    end

    assign out = out_q;
endmodule

// File: rtl/irqd_vector.sv
module irqd_vector
    import irqd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ack_done,
    input  logic ack_none,
    input  lvl_t lvl,
    output vec_t vec
);
    vec_t vec_q;

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else if (ack_done)
            vec_q <= ack_none ? vec_t'(VEC_SPURIOUS) : auto_vec(lvl);
    end

    assign vec = vec_q;
endmodule

// File: rtl/irq_level_decoder.sv
module irq_level_decoder
    import irqd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] irq_pin_n,
    input  logic [LVL_W-1:0] ipl_mask,
    input  logic             nmi_clear,
    input  logic             ack_done,
    input  logic             ack_none,
    output logic             irq_req,
    output logic [LVL_W-1:0] irq_level,
    output logic [VEC_W-1:0] vec_num
);
    lvl_t     lvl_stable;
    logic     nmi_pend;
    irq_out_t sel_out;

    irqd_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst        (rst),
        .pins_n     (irq_pin_n),
        .lvl_stable (lvl_stable)
    );

    irqd_nmi i_nmi (
        .clk   (clk),
        .rst   (rst),
        .lvl   (lvl_stable),
        .clear (nmi_clear),
        .pend  (nmi_pend)
    );

    irqd_select i_select (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl_stable),
        .mask     (ipl_mask),
        .nmi_pend (nmi_pend),
        .out      (sel_out)
    );

    irqd_vector i_vector (
        .clk      (clk),
        .rst      (rst),
        .ack_done (ack_done),
        .ack_none (ack_none),
        .lvl      (sel_out.lvl),
        .vec      (vec_num)
    );

    assign irq_req   = sel_out.req;
    assign irq_level = sel_out.lvl;
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] irq_pin_n,
    input logic [LVL_W-1:0] ipl_mask,
    input logic             nmi_clear,
    input logic             ack_done,
    input logic             ack_none,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level,
    input logic [VEC_W-1:0] vec_num
);
    // R1: level 0 never shows with a request, and no request means level 0
    assert_req_level_R1: assert property (@(posedge clk) disable iff (rst)
        (irq_req == (irq_level != '0)));

    // R2: a maskable request is strictly above the mask seen one cycle before
    assert_mask_strict_R2: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_level != LVL_NMI) |-> ($past(ipl_mask) < irq_level));

    // R4: a level-7 request holds while no clear is given
    assert_nmi_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (irq_req && irq_level == LVL_NMI && !nmi_clear && !$past(nmi_clear))
        |=> (irq_req && irq_level == LVL_NMI));

    // R7: an acknowledge with a responder yields the autovector
    assert_autovec_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_done && !ack_none) |=> (vec_num == VEC_W'(VEC_SPURIOUS) + VEC_W'($past(irq_level))));

    // R8: an acknowledge without a responder yields the spurious vector
    assert_spurious_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_done && ack_none) |=> (vec_num == VEC_W'(VEC_SPURIOUS)));

    // R8: the vector changes only after an acknowledge
    assert_vec_stable_R8: assert property (@(posedge clk) disable iff (rst)
        !ack_done |=> $stable(vec_num));
endmodule

bind irq_level_decoder irqd_checker i_irqd_checker (.*);

// File: tb/test_irq_level_decoder.sv
module test_irq_level_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] irq_pin_n;
    logic [2:0] ipl_mask;
    logic       nmi_clear;
    logic       ack_done;
    logic       ack_none;
    logic       irq_req;
    logic [2:0] irq_level;
    logic [7:0] vec_num;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_level_decoder i_irq_level_decoder (
        .clk       (clk),
        .rst       (rst),
        .irq_pin_n (irq_pin_n),
        .ipl_mask  (ipl_mask),
        .nmi_clear (nmi_clear),
        .ack_done  (ack_done),
        .ack_none  (ack_none),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .vec_num   (vec_num)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_level(input int l);
        irq_pin_n = ~3'(l);
    endtask

    // return to level 0 and let the pipeline settle
    task automatic idle();
        set_level(0);
        cycles(8);
    endtask

    task automatic t_reset();
        rst = 1'b1; irq_pin_n = 3'b111; ipl_mask = 3'd0;
        nmi_clear = 1'b0; ack_done = 1'b0; ack_none = 1'b0;
        cycles(3);
        rst = 1'b0;
        cycles(1);
        check("R9 req", int'(irq_req), 0);
        check("R9 level", int'(irq_level), 0);
        check("R9 vec", int'(vec_num), 0);
        cycles(6);
        check("R1 all pins high no request", int'(irq_req), 0);
    endtask

    task automatic t_latency();
        ipl_mask = 3'd0;
        set_level(3);
        cycles(4);
        check("R6 not yet after 4 edges", int'(irq_req), 0);
        cycles(1);
        check("R6 request after 5 edges", int'(irq_req), 1);
        check("R1 level from inverted pins", int'(irq_level), 3);
        idle();
    endtask

    task automatic t_masking();
        ipl_mask = 3'd4;
        set_level(3);
        cycles(8);
        check("R2 below mask", int'(irq_req), 0);
        check("R2 below mask level", int'(irq_level), 0);
        set_level(4);
        cycles(8);
        check("R2 equal to mask", int'(irq_req), 0);
        set_level(5);
        cycles(8);
        check("R2 above mask", int'(irq_req), 1);
        check("R2 above mask level", int'(irq_level), 5);
        ipl_mask = 3'd5;
        cycles(1);
        check("R6 mask raise takes effect", int'(irq_req), 0);
        ipl_mask = 3'd2;
        cycles(1);
        check("R6 mask drop takes effect", int'(irq_req), 1);
        set_level(6);
        ipl_mask = 3'd6;
        cycles(8);
        check("R2 level 6 under mask 6", int'(irq_req), 0);
        idle();
    endtask

    task automatic t_glitch();
        ipl_mask = 3'd0;
        set_level(5);
        cycles(1);
        set_level(0);
        for (int i = 0; i < 8; i++) begin
            cycles(1);
            check("R5 one-cycle pulse ignored", int'(irq_req), 0);
        end
    endtask

    task automatic t_nmi();
        ipl_mask = 3'd7;
        set_level(7);
        cycles(5);
        check("R3 not yet", int'(irq_req), 0);
        cycles(1);
        check("R3 level 7 under mask 7", int'(irq_req), 1);
        check("R3 level", int'(irq_level), 7);
        cycles(5);
        check("R4 held before clear", int'(irq_req), 1);
        nmi_clear = 1'b1;
        cycles(1);
        nmi_clear = 1'b0;
        cycles(1);
        check("R4 cleared", int'(irq_req), 0);
        cycles(6);
        check("R4 pins still at 7, no new request", int'(irq_req), 0);
        set_level(0);
        cycles(6);
        set_level(7);
        cycles(6);
        check("R4 new edge after leaving 7", int'(irq_req), 1);
        check("R4 new edge level", int'(irq_level), 7);
        ipl_mask = 3'd0;
        nmi_clear = 1'b1;
        cycles(1);
        nmi_clear = 1'b0;
        set_level(0);
        cycles(8);
    endtask

    task automatic ack(input bit none);
        ack_done = 1'b1;
        ack_none = none;
        cycles(1);
        ack_done = 1'b0;
        ack_none = 1'b0;
        cycles(1);
    endtask

    task automatic t_vectors();
        ipl_mask = 3'd0;
        for (int l = 1; l <= 6; l += 5) begin
            set_level(l);
            cycles(8);
            ack(1'b0);
            check("R7 autovector", int'(vec_num), 24 + l);
        end
        ack(1'b1);
        check("R8 spurious vector", int'(vec_num), 24);
        set_level(0);
        cycles(6);
        set_level(7);
        cycles(8);
        ack(1'b0);
        check("R7 autovector level 7", int'(vec_num), 31);
        nmi_clear = 1'b1;
        cycles(1);
        nmi_clear = 1'b0;
        idle();
    endtask

    initial begin
        t_reset();
        t_latency();
        t_masking();
        t_glitch();
        t_nmi();
        t_vectors();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule